// File: doc/BRIEF.md
# Time-Sliced Round-Robin Arbiter

This block shares one resource among four requesters. Each requester raises its bit of a request vector. The arbiter answers with a registered one-hot grant vector. A one-hot priority pointer decides who is served first. A requester that wins keeps the grant for a time slice of at most four consecutive cycles, provided it keeps requesting. Priority then moves on to the next position in a rotating order that runs from bit 3 down to bit 0 and wraps back to bit 3.

When the position holding priority is idle, a combinational search walks the remaining positions in the same cycle and picks the first active requester. No clock cycles are spent stepping through idle positions. A requester that drops its request in the middle of a slice loses the grant on the next edge. If the only active requester is the one whose slice has just run out, that requester is granted again with a fresh slice.

Top module: `slice_rr_arbiter`

## Requirements
- R1: The grant vector is always one-hot or all zeros.
- R2: An asynchronous active-low reset drives the grant to 0000 at once, clears the slice counter, and places the priority pointer on bit 3 (1000). With requests 1010 in the first cycle after reset, bit 3 wins.
- R3: The search visits positions in the order bit 3, bit 2, bit 1, bit 0, then back to bit 3. It starts at the pointer, and the first requesting position wins. The grant appears on the next rising edge with no idle cycles, even when the winner is several positions away from the pointer (requests 0010, pointer 1000 → grant 0010). The pointer moves to the winner.
- R4: A grantee that keeps requesting keeps its grant for exactly four consecutive cycles, measured by a 2-bit slice counter that goes 0, 1, 2, 3.
- R5: When a slice ends with the counter at 3, the search starts at the position after the grantee in the rotating order. If no other requester is active, the grantee is granted again with the counter restarted at 0.
- R6: If a grantee drops its request in the middle of a slice, its grant is removed on the next edge and the slice counter clears. A later grant to the same requester therefore receives a full four-cycle slice.
- R7: When no request is active, the next grant is 0000 and the pointer does not move.
- R8: A grant is only ever given to a requester whose request bit was high at the edge that loaded the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Request vector, one bit per requester |
| grant | output | 4 | Registered one-hot grant, or 0000 |

## Verification
On every cycle, the assertions check four things:
- The grant is one-hot or zero.
- Every grant matches a request seen at the loading edge.
- The pointer sits on the current grantee, and an idle cycle leaves it in place.
- The counter steps by one while a slice holds, clears when the grantee drops its request, and an expiring slice hands over whenever another requester waits.

Some behaviours can only be shown by the bench's scenarios. These are the exact search order and wrap-around from a given pointer, the length of a full slice, the re-grant of a lone requester after expiry, the restart to a full slice after a mid-slice drop, and the immediate clearing by the asynchronous reset.

// File: rtl/rrts_pkg.sv
// Package: shared types for the time-sliced round-robin arbiter.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package rrts_pkg;

    // Decision taken for the current grantee each cycle
    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,   // no grant is currently held
        SL_HOLD   = 2'd1,   // grantee still requesting, slice not used up
        SL_EXPIRE = 2'd2,   // grantee still requesting, last slice cycle
        SL_DROP   = 2'd3    // grantee released its request mid-slice
    } slice_state_e;

endpackage

// File: rtl/rrts_search.sv
// Module: rrts_search
// Combinational priority search. Starting at the one-hot start position, it
// walks downward (bit N-1 toward bit 0, wrapping) and returns the first
// requesting position as a one-hot vector.
// Assumes: start is one-hot; the loop has a fixed bound of N steps.
module rrts_search #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] start,
    output logic [N-1:0] win,
    output logic         found
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] start_idx;

    // Convert the one-hot start position to an index
    always_comb begin
        start_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (start[i]) start_idx = IDX_W'(i);
        end
    end

    // Walk N positions downward from start and stop at the first request
    always_comb begin
        logic [IDX_W-1:0] idx;
        win   = '0;
        found = 1'b0;
        idx   = start_idx;
        for (int k = 0; k < N; k++) begin
            if (!found && req[idx]) begin
                win[idx] = 1'b1;
                found    = 1'b1;
            end
            idx = (idx == '0) ? IDX_LAST : idx - 1'b1;
        end
    end

endmodule

// File: rtl/rrts_slice.sv
// Module: rrts_slice
// Slice bookkeeping for the current grantee. It classifies the cycle (idle,
// hold, expire, drop) and keeps the slice counter that limits one grantee
// to 2**CNT_W consecutive cycles.
// Assumes: grant_q is the registered one-hot grant of the top module.
module rrts_slice
    import rrts_pkg::*;
#(
    parameter int N     = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     grant_q,
    output slice_state_e     state,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic have_grant;
    logic still_req;

    assign have_grant = |grant_q;
    assign still_req  = |(req & grant_q);

    // Classify what the current grantee does this cycle
    always_comb begin
        if (!have_grant)            state = SL_IDLE;
        else if (!still_req)        state = SL_DROP;
        else if (cnt_q == CNT_LAST) state = SL_EXPIRE;
        else                        state = SL_HOLD;
    end

    // Slice counter: count while holding, restart on any other decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (state == SL_HOLD)  cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    // R4: a held slice advances the counter by exactly one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SL_HOLD) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R6: a dropped grantee leaves the counter cleared
    a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SL_DROP) |=> (cnt_q == '0));

endmodule

// File: rtl/slice_rr_arbiter.sv
// Module: slice_rr_arbiter
// Four-requester round-robin arbiter with time slices. A one-hot pointer
// rotates from bit N-1 toward bit 0. The grantee keeps its grant for up to
// 2**CNT_W cycles, and idle positions are skipped in a single cycle.
// Assumes: req is synchronous to clk; rst_n is asynchronous and active low.
module slice_rr_arbiter
    import rrts_pkg::*;
#(
    parameter int N     = 4,
    parameter int CNT_W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam logic [N-1:0] PTR_INIT = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0]     ptr_q;
    logic [N-1:0]     grant_q;
    logic [N-1:0]     start_vec;
    logic [N-1:0]     win;
    logic             found;
    logic [N-1:0]     nxt_grant;
    logic [N-1:0]     nxt_ptr;
    logic [N-1:0]     after_grantee;
    slice_state_e     state;
    logic [CNT_W-1:0] cnt_q;

    rrts_slice #(.N(N), .CNT_W(CNT_W)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .grant_q (grant_q),
        .state   (state),
        .cnt_q   (cnt_q)
    );

    // Position that follows the grantee in the downward rotating order
    assign after_grantee = {grant_q[0], grant_q[N-1:1]};

    // Choose where the search begins: after the grantee on expiry, else the pointer
    assign start_vec = (state == SL_EXPIRE) ? after_grantee : ptr_q;

    rrts_search #(.N(N)) u_search (
        .req   (req),
        .start (start_vec),
        .win   (win),
        .found (found)
    );

    // Next grant and pointer: keep while holding, otherwise take the search result
    always_comb begin
        if (state == SL_HOLD) begin
            nxt_grant = grant_q;
            nxt_ptr   = ptr_q;
        end else if (found) begin
            nxt_grant = win;
            nxt_ptr   = win;
        end else begin
            nxt_grant = '0;
            nxt_ptr   = ptr_q;
        end
    end

    // Register grant and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            ptr_q   <= PTR_INIT;
        end else begin
            grant_q <= nxt_grant;
            ptr_q   <= nxt_ptr;
        end
    end

    assign grant = grant_q;

    // R1: never more than one grant
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R8: a held grant matches a request seen at the loading edge
    a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0) |-> ((grant_q & $past(req)) != '0));

    // R3: the pointer sits on the current grantee
    a_r3_ptr_on_grantee: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q != '0) |-> (ptr_q == grant_q));

    // R7: no requests means no grant and a still pointer
    a_r7_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> ((grant_q == '0) && $stable(ptr_q)));

    // R5: an expiring slice hands over when another requester waits
    a_r5_expire_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SL_EXPIRE) && ((req & ~grant_q) != '0))
            |=> (grant_q != $past(grant_q)));

endmodule

// File: tb/slice_rr_arbiter_bench.sv
module slice_rr_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = 4'b0000;
    logic [3:0] grant;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    slice_rr_arbiter u_slice_rr_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant)
    );

    always #4 clk = ~clk;

    // Upper nibble: request applied; lower nibble: grant expected after the edge
    localparam logic [7:0] VEC [0:25] = '{
        8'h00, 8'h22, 8'h22, 8'h22, 8'h22, 8'h22,
        8'hA2, 8'hA2, 8'hA2, 8'hA8, 8'hA8, 8'h22,
        8'h00, 8'h51, 8'h51, 8'h51, 8'h51, 8'h54,
        8'hF4, 8'hF4, 8'hF4, 8'hF2, 8'hF2, 8'hF2,
        8'hF2, 8'hF1
    };

    function automatic string tag_for(int row);
        case (row)
            0, 12:          return "R7";
            1, 13:          return "R3";
            5, 9, 17, 21, 25: return "R5";
            11:             return "R6";
            default:        return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(logic [3:0] r, logic [3:0] exp, string tag);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
        check(tag, grant, exp);
        checks++;
        if ($countones(grant) > 1) begin
            failures++;
            $display("FAIL R1 grant actual=%b expected=onehot0", grant);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2", grant, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < 26; i++) begin
            step(VEC[i][7:4], VEC[i][3:0], tag_for(i));
        end

        // R2: asynchronous reset clears grant mid-cycle, pointer back to bit 3
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1 check("R2", grant, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b1010, 4'b1000, "R2");

        // R3: from reset pointer, lone request at bit 0 wins after a full wrap search
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0001, 4'b0001, "R3");

        // R6: drop mid-slice, then the same requester gets a full fresh slice
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b1000, 4'b1000, "R6");
        step(4'b1000, 4'b1000, "R6");
        step(4'b0000, 4'b0000, "R6");
        step(4'b1010, 4'b1000, "R6");
        step(4'b1010, 4'b1000, "R6");
        step(4'b1010, 4'b1000, "R6");
        step(4'b1010, 4'b1000, "R6");
        step(4'b1010, 4'b0010, "R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule